// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one channel of a counting timer. An up-counter advances on ticks from a prescaler. The prescaler divides the block clock by a power of two that a control field selects. The counter is compared with a programmable compare register. When the counter equals the compare value at a tick, the channel sets a sticky match flag. In periodic operation the counter also restarts from zero on that tick, so software sees each wrap without losing one. An interrupt output follows the flags while an enable field is nonzero.

Software reaches three channel registers through a small memory-mapped window: control/status, count and compare. It starts and stops the channel through a separate shared run register in which this channel owns a single bit. The counter width is a parameter, 16 or 32. The width sets the register spacing, the control field layout and the flag positions.

Top module: `match_timer_chan`

## Requirements
- R1: Channel registers are selected by word index (0 control/status, 1 count, 2 compare). The byte address is the index times 2 in the 16-bit variant and times 4 in the 32-bit variant. Index 3 reads zero and ignores writes.
- R2: After reset, count and control/status read zero, compare reads all ones for the configured width, the run bit reads zero and irq is low.
- R3: A write with the run-register select loads only wdata bit CH_BIT into the run bit. A read returns the run bit at position CH_BIT and zero everywhere else.
- R4: Each variant has its own clock-select field. In the 16-bit variant it is bits 1:0, and value k gives divide by 2^(3+2k). In the 32-bit variant it is bits 2:0: values 4..7 divide by 2^(3+2(v-4)) and values 0..3 divide by 1. N clocks after the run bit is set, the count equals floor(N/D).
- R5: At a tick with count equal to compare, the match flag is set. The flag is bit 7 in the 16-bit variant and bit 15 in the 32-bit variant. The count becomes zero when periodic mode is on. Periodic mode is always on in the 16-bit variant and is bit 8 in the 32-bit variant.
- R6: With bit 8 clear, the 32-bit counter runs past the compare value while still setting the match flag. A step from all ones to zero sets the wrap flag, bit 14.
- R7: A flag stays set until a control/status write carries 0 in its bit. Writing 1 there has no effect. A hardware set in the same cycle as a clearing write wins.
- R8: irq is high exactly while a flag is set and the interrupt-enable field is nonzero. The field is bit 6 in the 16-bit variant and bits 5:4 in the 32-bit variant. Writing all zeros to control/status therefore drops irq.
- R9: While the run bit is clear, the count holds and the prescaler returns to zero, so a restart begins a full division period.
- R10: Writes to count or compare take effect while the channel runs. The written count appears right after the write edge and takes priority over a tick in that cycle. Later matches use the new compare value.
- R11: Only the control fields are stored: bits 6,1,0 in the 16-bit variant, bits 8,7,5,4,2,1,0 in the 32-bit variant. All other non-flag bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 1 | Access targets the channel register window |
| start_sel | input | 1 | Access targets the shared run register |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | ADDR_W (4) | Byte address inside the channel window |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Combinational read data for the selected register |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check four things. The match flag stays sticky between clearing writes. A stopped channel holds its count. A periodic match returns the count to zero. irq never rises without a set flag, and the flag rises only after a count tick. The bench must show the behaviours that involve arithmetic and timing. These are the exact tick cycle for each divisor and compare value, the run-register bit isolation, the priority of a hardware set over a clearing write, the wrap flag in free-running mode, and a compare value changed in mid-count.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic [1:0] {
    IDX_CTRL  = 2'd0,
    IDX_COUNT = 2'd1,
    IDX_MATCH = 2'd2,
    IDX_NONE  = 2'd3
  } reg_idx_e;

  localparam int PRE_W = 10;

  // log2 of the prescaler divisor from the clock-select field
  function automatic logic [3:0] div_log2(input logic narrow, input logic [2:0] sel);
    if (!narrow && !sel[2]) return 4'd0;
    return 4'd3 + {1'b0, sel[1:0], 1'b0};
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int PW = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] dlog,
  output logic       tick
);
  logic [PW-1:0] pre_q, pre_d, limit;

  always_comb begin
    limit = (PW'(1) << dlog) - PW'(1);
    tick  = run && (pre_q >= limit);
    if (!run || tick) pre_d = '0;
    else              pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wrap_at_match,
  input  logic [W-1:0] match_val,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         hit_match,
  output logic         hit_wrap
);
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    hit_match = tick && (count == match_val);
    hit_wrap  = tick && (&count) && !(hit_match && wrap_at_match);
    cnt_en    = load_en || tick;
    if (load_en)                         cnt_d = load_val;
    else if (hit_match && wrap_at_match) cnt_d = '0;
    else                                 cnt_d = count + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_d;
  end
endmodule

// File: rtl/mt_ctrl.sv
module mt_ctrl #(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        hit_match,
  input  logic        hit_wrap,
  output logic [15:0] ctrl_rd,
  output logic        ie,
  output logic [3:0]  dlog,
  output logic        periodic,
  output logic        flag_m,
  output logic        flag_w
);
  import mt_pkg::*;

  localparam bit          NARROW = (W == 16);
  localparam logic [15:0] WMASK  = NARROW ? 16'h0043 : 16'h01B7;
  localparam int          FM_BIT = NARROW ? 7 : 15;
  localparam int          FW_BIT = 14;

  logic [15:0] field_q, field_d;
  logic        fm_d, fw_d;

  always_comb begin
    field_d = wr ? (wdata & WMASK) : field_q;
    fm_d    = hit_match || (flag_m && !(wr && !wdata[FM_BIT]));
    fw_d    = NARROW ? 1'b0 : (hit_wrap || (flag_w && !(wr && !wdata[FW_BIT])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
      flag_m  <= 1'b0;
      flag_w  <= 1'b0;
    end else begin
      field_q <= field_d;
      flag_m  <= fm_d;
      flag_w  <= fw_d;
    end
  end

  always_comb begin
    ctrl_rd  = field_q | (16'(flag_m) << FM_BIT) | (16'(flag_w) << FW_BIT);
    ie       = NARROW ? field_q[6] : (|field_q[5:4]);
    dlog     = div_log2(NARROW, NARROW ? {1'b1, field_q[1:0]} : field_q[2:0]);
    periodic = NARROW ? 1'b1 : field_q[8];
  end
endmodule

// File: rtl/match_timer_chan.sv
module match_timer_chan #(
  parameter int CNT_W  = 16,
  parameter int CH_BIT = 0,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_sel,
  input  logic              start_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  import mt_pkg::*;

  localparam bit NARROW = (CNT_W == 16);
  localparam int SHIFT  = NARROW ? 1 : 2;

  logic [ADDR_W-1:0] word;
  reg_idx_e          idx;
  logic              wr_ctrl, wr_cnt, wr_cmp, wr_run;
  logic              run_q;
  logic [CNT_W-1:0]  cmp_q, count;
  logic              tick, hit_match, hit_wrap;
  logic [15:0]       ctrl_rd;
  logic              ie, periodic, flag_m, flag_w;
  logic [3:0]        dlog;

  always_comb begin
    word    = addr >> SHIFT;
    idx     = (word > ADDR_W'(2)) ? IDX_NONE : reg_idx_e'(word[1:0]);
    wr_ctrl = chan_sel && wr_en && (idx == IDX_CTRL);
    wr_cnt  = chan_sel && wr_en && (idx == IDX_COUNT);
    wr_cmp  = chan_sel && wr_en && (idx == IDX_MATCH);
    wr_run  = start_sel && wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cmp_q <= '1;
    end else begin
      if (wr_run) run_q <= wdata[CH_BIT];
      if (wr_cmp) cmp_q <= wdata;
    end
  end

  mt_prescaler #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .dlog(dlog), .tick(tick)
  );

  mt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap_at_match(periodic),
    .match_val(cmp_q), .load_en(wr_cnt), .load_val(wdata),
    .count(count), .hit_match(hit_match), .hit_wrap(hit_wrap)
  );

  mt_ctrl #(.W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(wdata[15:0]),
    .hit_match(hit_match), .hit_wrap(hit_wrap), .ctrl_rd(ctrl_rd),
    .ie(ie), .dlog(dlog), .periodic(periodic), .flag_m(flag_m), .flag_w(flag_w)
  );

  always_comb begin
    rdata = '0;
    if (start_sel) rdata = CNT_W'(run_q) << CH_BIT;
    else if (chan_sel) begin
      case (idx)
        IDX_CTRL:  rdata = CNT_W'(ctrl_rd);
        IDX_COUNT: rdata = count;
        IDX_MATCH: rdata = cmp_q;
        default:   rdata = '0;
      endcase
    end
    irq = ie && (flag_m || flag_w);
  end
endmodule

// File: rtl/mt_checker.sv
module mt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp,
  input logic         flag_m,
  input logic         flag_w,
  input logic         irq,
  input logic         wr_cnt,
  input logic         wr_ctrl,
  input logic         periodic
);
  p_sticky_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_m && !wr_ctrl) |=> flag_m);

  p_halt_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(count));

  p_periodic_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (count == cmp) && periodic && !wr_cnt) |=> (count == '0));

  p_flag_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_m) |-> $past(tick));

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_m || flag_w));
endmodule

bind match_timer_chan mt_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q), .count(count),
  .cmp(cmp_q), .flag_m(flag_m), .flag_w(flag_w), .irq(irq),
  .wr_cnt(wr_cnt), .wr_ctrl(wr_ctrl), .periodic(periodic)
);

// File: tb/match_timer_chan_bench.sv
`timescale 1ns/100ps
module match_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic        csel_a, ssel_a, csel_b, ssel_b;
  logic [15:0] rd_a;
  logic [31:0] rd_b;
  logic        irq_a, irq_b;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  // narrow channel owning run bit 2
  match_timer_chan #(.CNT_W(16), .CH_BIT(2)) u_match_timer_chan (
    .clk(clk), .rst_n(rst_n), .chan_sel(csel_a), .start_sel(ssel_a), .wr_en(wr_en),
    .addr(addr), .wdata(wdata[15:0]), .rdata(rd_a), .irq(irq_a)
  );

  // wide channel owning run bit 0
  match_timer_chan #(.CNT_W(32), .CH_BIT(0)) u_match_timer_chan_w32 (
    .clk(clk), .rst_n(rst_n), .chan_sel(csel_b), .start_sel(ssel_b), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rd_b), .irq(irq_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input bit wide, input bit start, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    csel_a = !wide && !start; ssel_a = !wide && start;
    csel_b = wide && !start;  ssel_b = wide && start;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    #1;
    wr_en = 1'b0; csel_a = 0; ssel_a = 0; csel_b = 0; ssel_b = 0;
  endtask

  task automatic get(input bit wide, input bit start, input logic [3:0] a, output logic [31:0] v);
    csel_a = !wide && !start; ssel_a = !wide && start;
    csel_b = wide && !start;  ssel_b = wide && start;
    addr = a;
    #0.3;
    v = wide ? rd_b : {16'h0, rd_a};
    csel_a = 0; ssel_a = 0; csel_b = 0; ssel_b = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int d;
    rst_n = 1'b0; wr_en = 0; addr = 0; wdata = 0;
    csel_a = 0; ssel_a = 0; csel_b = 0; ssel_b = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;

    // R2 reset state, R1 word spacing per variant
    get(0, 0, 4'd0, v); check("R2 narrow ctrl", v, 32'h0);
    get(0, 0, 4'd2, v); check("R2 narrow count", v, 32'h0);
    get(0, 0, 4'd4, v); check("R2 R1 narrow compare", v, 32'hFFFF);
    get(1, 0, 4'd8, v); check("R2 R1 wide compare", v, 32'hFFFF_FFFF);
    get(0, 1, 4'd0, v); check("R2 run bit", v, 32'h0);
    check("R2 irq", {30'h0, irq_a, irq_b}, 32'h0);

    // R1 index 3 is empty
    put(0, 0, 4'd6, 32'h1234);
    #0.5; get(0, 0, 4'd6, v); check("R1 unused index", v, 32'h0);

    // R11 writable field masks
    put(0, 0, 4'd0, 32'hFFFF);
    #0.5; get(0, 0, 4'd0, v); check("R11 narrow mask", v, 32'h0043);
    put(1, 0, 4'd0, 32'hFFFF);
    #0.5; get(1, 0, 4'd0, v); check("R11 wide mask", v, 32'h01B7);
    put(1, 0, 4'd0, 32'h01A4);
    #0.5; get(1, 0, 4'd0, v); check("R11 wide ctrl value", v, 32'h01A4);

    // R3 only the owned run bit is used
    put(0, 0, 4'd0, 32'h0040);
    put(0, 1, 4'd0, 32'hFFFB);
    #0.5; get(0, 1, 4'd0, v); check("R3 foreign bits ignored", v, 32'h0);
    repeat (20) @(posedge clk);
    #0.5; get(0, 0, 4'd2, v); check("R3 count idle", v, 32'h0);
    put(0, 1, 4'd0, 32'h0004);
    #0.5; get(0, 1, 4'd0, v); check("R3 owned bit readback", v, 32'h0004);

    // R4 R5 R8 sweep over divisor and compare value (narrow)
    for (int k = 0; k < 4; k++) begin
      for (int ci = 0; ci < 3; ci++) begin
        automatic int c = (ci == 0) ? 0 : ((ci == 1) ? 1 : 3);
        d = 1 << (3 + 2 * k);
        put(0, 1, 4'd0, 32'h0);
        put(0, 0, 4'd0, 32'h0040 | k);
        put(0, 0, 4'd4, c);
        put(0, 0, 4'd2, 32'h0);
        put(0, 1, 4'd0, 32'h0004);
        repeat (d * (c + 1) - 1) @(posedge clk);
        #0.5;
        get(0, 0, 4'd2, v); check("R4 count before match", v, c);
        get(0, 0, 4'd0, v); check("R5 no flag yet", v, 32'h0040 | k);
        check("R8 irq low", {31'h0, irq_a}, 32'h0);
        @(posedge clk);
        #0.5;
        get(0, 0, 4'd2, v); check("R5 count cleared", v, 32'h0);
        get(0, 0, 4'd0, v); check("R5 flag bit7", v, 32'h00C0 | k);
        check("R8 irq high", {31'h0, irq_a}, 32'h1);
      end
    end

    // R7 sticky flag, write of 1 ignored, write of 0 clears
    put(0, 1, 4'd0, 32'h0);
    put(0, 0, 4'd0, 32'h00C3);
    #0.5; get(0, 0, 4'd0, v); check("R7 write one keeps flag", v, 32'h00C3);
    put(0, 0, 4'd0, 32'h0043);
    #0.5; get(0, 0, 4'd0, v); check("R7 write zero clears", v, 32'h0043);
    check("R8 irq after clear", {31'h0, irq_a}, 32'h0);

    // R8 enable off: flag without irq
    put(0, 0, 4'd0, 32'h0000);
    put(0, 0, 4'd4, 32'h0);
    put(0, 0, 4'd2, 32'h0);
    put(0, 1, 4'd0, 32'h0004);
    repeat (8) @(posedge clk);
    #0.5; get(0, 0, 4'd0, v); check("R8 flag with enable off", v, 32'h0080);
    check("R8 irq masked", {31'h0, irq_a}, 32'h0);

    // R9 halt and prescaler restart
    put(0, 1, 4'd0, 32'h0);
    put(0, 0, 4'd0, 32'h0040);
    put(0, 0, 4'd4, 32'hFFFF);
    put(0, 0, 4'd2, 32'h0);
    put(0, 1, 4'd0, 32'h0004);
    repeat (80) @(posedge clk);
    put(0, 1, 4'd0, 32'h0);
    #0.5; get(0, 0, 4'd2, v); check("R9 count at stop", v, 32'd10);
    repeat (40) @(posedge clk);
    #0.5; get(0, 0, 4'd2, v); check("R9 count held", v, 32'd10);
    put(0, 1, 4'd0, 32'h0004);
    repeat (7) @(posedge clk);
    #0.5; get(0, 0, 4'd2, v); check("R9 prescaler restarted", v, 32'd10);
    @(posedge clk);
    #0.5; get(0, 0, 4'd2, v); check("R9 first tick after restart", v, 32'd11);

    // R10 live compare and count writes (edges 9 and 10 after restart)
    put(0, 0, 4'd4, 32'd12);
    put(0, 0, 4'd2, 32'd3);
    #0.5; get(0, 0, 4'd2, v); check("R10 count load", v, 32'd3);
    repeat (77) @(posedge clk);
    #0.5; get(0, 0, 4'd2, v); check("R10 reaches new compare", v, 32'd12);
    get(0, 0, 4'd0, v); check("R10 no flag before", v, 32'h0040);
    @(posedge clk);
    #0.5; get(0, 0, 4'd2, v); check("R10 wraps at new compare", v, 32'h0);
    get(0, 0, 4'd0, v); check("R10 flag at new compare", v, 32'h00C0);
    put(0, 1, 4'd0, 32'h0);

    // R4 R5 wide variant, divide by 8 periodic
    put(1, 0, 4'd8, 32'd2);
    put(1, 0, 4'd4, 32'h0);
    put(1, 1, 4'd0, 32'h1);
    repeat (23) @(posedge clk);
    #0.5; get(1, 0, 4'd4, v); check("R4 wide count", v, 32'd2);
    @(posedge clk);
    #0.5; get(1, 0, 4'd4, v); check("R5 wide cleared", v, 32'd0);
    get(1, 0, 4'd0, v); check("R5 wide flag bit15", v, 32'h81A4);
    check("R8 wide irq", {31'h0, irq_b}, 32'h1);
    put(1, 1, 4'd0, 32'h0);
    put(1, 0, 4'd0, 32'h01A4);
    #0.5; get(1, 0, 4'd0, v); check("R7 wide clear", v, 32'h01A4);

    // R7 hardware set beats clearing write (divide by 1, compare 0)
    put(1, 0, 4'd0, 32'h0120);
    put(1, 0, 4'd8, 32'h0);
    put(1, 0, 4'd4, 32'h0);
    put(1, 1, 4'd0, 32'h1);
    repeat (3) @(posedge clk);
    put(1, 0, 4'd0, 32'h0120);
    #0.5; get(1, 0, 4'd0, v); check("R7 set wins over clear", v, 32'h8120);
    put(1, 1, 4'd0, 32'h0);

    // R6 free-running with wrap flag
    put(1, 0, 4'd0, 32'h0020);
    put(1, 0, 4'd8, 32'h1);
    put(1, 0, 4'd4, 32'hFFFF_FFFE);
    put(1, 1, 4'd0, 32'h1);
    repeat (4) @(posedge clk);
    #0.5; get(1, 0, 4'd4, v); check("R6 count past compare", v, 32'd2);
    get(1, 0, 4'd0, v); check("R6 match and wrap flags", v, 32'hC020);
    check("R8 irq from flags", {31'h0, irq_b}, 32'h1);
    put(1, 0, 4'd0, 32'h0000);
    #0.5; check("R8 zero write drops irq", {31'h0, irq_b}, 32'h0);

    finish_run();
  end
endmodule